// File: doc/BRIEF.md
# Character LCD Nibble-Bus Controller

This block owns the 4-bit parallel bus of a character LCD module, together with its register-select, read/write and enable strobes. When reset is released it waits out the display's power-up time. It then runs the fixed nibble handshake that places the module in 4-bit mode. After that it sends a short configuration list: line count, display and cursor options, clear, home and auto-increment entry. From then on it serves a host that offers command or character bytes on a valid/ready handshake, and that can ask for the status byte through a separate request/valid port.

Every byte, whether written or read, crosses the bus as two nibbles, high nibble first. Each nibble is framed by an enable pulse whose width, like every other wait, comes from a single down-counter. That counter is loaded from constants derived from the clock-frequency parameter. Before each byte write the block reads the status byte and repeats the read until the busy bit is clear. While it reads, it releases the data lines. When a transfer ends it drives the data lines high again.

Top module: `lcd4_ctrl`

## Requirements
- R1: While reset is held and on the cycle after its release, the enable strobe is low, `cmd_ready` and `init_done` are low, and the data lines are driven (`lcd_d_oe`=1) with the value 4'hF.
- R2: The first enable rising edge after reset comes no sooner than PWRUP_US microseconds of clock cycles after reset release.
- R3: The handshake writes exactly four single nibbles with RS=0 and R/W=0, with values 0x3, 0x3, 0x3 and then 0x2. The low time after the first strobe is at least FIRST_GAP_US, and the low time after each of the other three strobes is at least NIB_GAP_US.
- R4: The configuration bytes are then written as commands (RS=0), in this order: 0x20 OR 0x08 when TWO_LINES; 0x0C OR 0x02 when CURSOR_ON, OR 0x01 when BLINK_ON; 0x01; 0x02; 0x06. `init_done` rises only after all five have been written.
- R5: Each byte crosses the bus as two enable pulses, carrying bits 7:4 first and bits 3:0 second. Every enable pulse stays high for at least STROBE_US of clock cycles.
- R6: RS is 1 for character bytes (`cmd_is_data`=1) and 0 for commands and status reads. R/W is 1 only during reads, and `lcd_d_oe` is 0 whenever R/W is 1. RS, R/W and the driven nibble do not change while enable is high.
- R7: Before every byte write the block reads the status byte (RS=0, R/W=1). While bit 7 of that byte is 1 it repeats the read, and it never writes a byte while the display reports busy.
- R8: `cmd_ready` is high only when the block is idle after configuration. It falls on the cycle after a byte is accepted and stays low until that byte has been written.
- R9: A `stat_req` seen while idle, with no `cmd_valid`, performs one status read. `stat_valid` is then high for exactly one cycle, and `stat_byte` holds {busy bit, 7-bit display address} as read.
- R10: Once a write completes and the block is idle, the data lines are driven with 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Host offers a byte |
| cmd_is_data | input | 1 | 1 = character byte, 0 = command |
| cmd_byte | input | 8 | Byte to write |
| cmd_ready | output | 1 | Block can accept a byte this cycle |
| stat_req | input | 1 | Request a status read |
| stat_valid | output | 1 | One-cycle pulse: `stat_byte` is fresh |
| stat_byte | output | 8 | Last status byte read {busy, address} |
| init_done | output | 1 | Handshake and configuration finished |
| lcd_rs | output | 1 | Register select to display |
| lcd_rw | output | 1 | Read (1) / write (0) to display |
| lcd_e | output | 1 | Enable strobe |
| lcd_d_out | output | 4 | Nibble driven onto the bus |
| lcd_d_oe | output | 1 | Bus output enable (0 = released) |
| lcd_d_in | input | 4 | Nibble read from the bus |

## Verification
The bench builds the block with CLK_HZ of 2 MHz. This gives two cycles per microsecond, so the 16 ms power-up wait and the 5 ms first gap shrink to a few tens of thousands of cycles, and the whole start-up sequence fits in one run. The bench sets TWO_LINES=1, CURSOR_ON=1 and BLINK_ON=0, so the two configurable command bytes take the values 0x28 and 0x0E. The display model holds its busy bit for two status reads after each write, so every write must be preceded by exactly three polls. Status reads taken straight after a set-address command return the busy bit set and then cleared over the same address.

// File: rtl/lcd4_ctrl.sv
module lcd4_ctrl #(
  parameter int CLK_HZ       = 50_000_000,
  parameter int PWRUP_US     = 16000,
  parameter int FIRST_GAP_US = 5000,
  parameter int NIB_GAP_US   = 64,
  parameter int STROBE_US    = 1,
  parameter bit TWO_LINES    = 1'b1,
  parameter bit CURSOR_ON    = 1'b0,
  parameter bit BLINK_ON     = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       cmd_is_data,
  input  logic [7:0] cmd_byte,
  output logic       cmd_ready,
  input  logic       stat_req,
  output logic       stat_valid,
  output logic [7:0] stat_byte,
  output logic       init_done,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [3:0] lcd_d_out,
  output logic       lcd_d_oe,
  input  logic [3:0] lcd_d_in
);

  localparam int CPU   = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int C_PWR = PWRUP_US * CPU;
  localparam int C_G1  = FIRST_GAP_US * CPU;
  localparam int C_GN  = NIB_GAP_US * CPU;
  localparam int C_STB = (STROBE_US * CPU < 1) ? 1 : STROBE_US * CPU;
  localparam int CW    = $clog2(C_PWR + 1) + 1;
  localparam logic [CW-1:0] K_PWR = CW'(C_PWR - 1);
  localparam logic [CW-1:0] K_G1  = CW'(C_G1 - 1);
  localparam logic [CW-1:0] K_GN  = CW'(C_GN - 1);
  localparam logic [CW-1:0] K_STB = CW'(C_STB - 1);
  localparam int NCFG = 5;
  localparam logic [7:0] FN_SET = 8'h20 | (TWO_LINES ? 8'h08 : 8'h00);
  localparam logic [7:0] DISP   = 8'h0C | (CURSOR_ON ? 8'h02 : 8'h00) | (BLINK_ON ? 8'h01 : 8'h00);

  typedef enum logic [3:0] {
    ST_PWR, ST_ISET, ST_IPUL, ST_IGAP, ST_LOAD, ST_IDLE, ST_SET, ST_PUL, ST_HOLD
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    ini;
  logic [2:0]    cfg;
  logic [7:0]    pend_byte;
  logic          pend_rs;
  logic          xf_rd;
  logic          xf_stat;
  logic          nib;
  logic [7:0]    rx;
  logic [7:0]    cfg_cmd;
  logic          done_q;
  logic          sv_q;
  logic [7:0]    sb_q;

  always_comb begin
    case (cfg)
      3'd0:    cfg_cmd = FN_SET;
      3'd1:    cfg_cmd = DISP;
      3'd2:    cfg_cmd = 8'h01;
      3'd3:    cfg_cmd = 8'h02;
      default: cfg_cmd = 8'h06;
    endcase
  end

  wire tick  = (cnt == '0);
  wire in_xf = (st == ST_SET) || (st == ST_PUL) || (st == ST_HOLD);
  wire in_ini = (st == ST_ISET) || (st == ST_IPUL) || (st == ST_IGAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_PWR;
      cnt       <= K_PWR;
      ini       <= '0;
      cfg       <= '0;
      pend_byte <= '0;
      pend_rs   <= 1'b0;
      xf_rd     <= 1'b0;
      xf_stat   <= 1'b0;
      nib       <= 1'b0;
      rx        <= '0;
      done_q    <= 1'b0;
      sv_q      <= 1'b0;
      sb_q      <= '0;
    end else begin
      sv_q <= 1'b0;
      if (!tick) cnt <= cnt - 1'b1;
      case (st)
        ST_PWR: if (tick) begin
          st  <= ST_ISET;
          cnt <= K_STB;
        end
        ST_ISET: if (tick) begin
          st  <= ST_IPUL;
          cnt <= K_STB;
        end
        ST_IPUL: if (tick) begin
          st  <= ST_IGAP;
          cnt <= (ini == 2'd0) ? K_G1 : K_GN;
        end
        ST_IGAP: if (tick) begin
          if (ini == 2'd3) st <= ST_LOAD;
          else begin
            st  <= ST_ISET;
            cnt <= K_STB;
          end
          ini <= ini + 1'b1;
        end
        ST_LOAD: begin
          if (cfg < 3'(NCFG)) begin
            pend_byte <= cfg_cmd;
            pend_rs   <= 1'b0;
            cfg       <= cfg + 1'b1;
            xf_rd     <= 1'b1;
            xf_stat   <= 1'b0;
            nib       <= 1'b0;
            st        <= ST_SET;
            cnt       <= K_STB;
          end else begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (cmd_valid) begin
            pend_byte <= cmd_byte;
            pend_rs   <= cmd_is_data;
            xf_rd     <= 1'b1;
            xf_stat   <= 1'b0;
            nib       <= 1'b0;
            st        <= ST_SET;
            cnt       <= K_STB;
          end else if (stat_req) begin
            xf_rd   <= 1'b1;
            xf_stat <= 1'b1;
            nib     <= 1'b0;
            st      <= ST_SET;
            cnt     <= K_STB;
          end
        end
        ST_SET: if (tick) begin
          st  <= ST_PUL;
          cnt <= K_STB;
        end
        ST_PUL: if (tick) begin
          if (xf_rd) begin
            if (nib) rx[3:0] <= lcd_d_in;
            else     rx[7:4] <= lcd_d_in;
          end
          st  <= ST_HOLD;
          cnt <= K_STB;
        end
        ST_HOLD: if (tick) begin
          if (!nib) begin
            nib <= 1'b1;
            st  <= ST_SET;
            cnt <= K_STB;
          end else if (xf_rd && xf_stat) begin
            sv_q <= 1'b1;
            sb_q <= rx;
            st   <= ST_IDLE;
          end else if (xf_rd) begin
            xf_rd <= rx[7];
            nib   <= 1'b0;
            st    <= ST_SET;
            cnt   <= K_STB;
          end else begin
            st <= ST_LOAD;
          end
        end
        default: st <= ST_PWR;
      endcase
    end
  end

  assign cmd_ready  = (st == ST_IDLE);
  assign init_done  = done_q;
  assign stat_valid = sv_q;
  assign stat_byte  = sb_q;
  assign lcd_e      = (st == ST_IPUL) || (st == ST_PUL);
  assign lcd_rw     = in_xf && xf_rd;
  assign lcd_rs     = in_xf && !xf_rd && pend_rs;
  assign lcd_d_oe   = !(in_xf && xf_rd);
  assign lcd_d_out  = in_ini ? ((ini == 2'd3) ? 4'h2 : 4'h3) :
                      (in_xf && !xf_rd) ? (nib ? pend_byte[3:0] : pend_byte[7:4]) : 4'hF;

  logic [CW-1:0] e_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     e_run <= '0;
    else if (lcd_e) e_run <= e_run + 1'b1;
    else            e_run <= '0;
  end

  p_e_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> (e_run >= CW'(C_STB)));
  p_read_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rw |-> !lcd_d_oe);
  p_ctl_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && $past(lcd_e)) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_d_out)));
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (init_done && !lcd_e));
  p_accept_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  p_stat_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);
  p_init_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !lcd_rs);

endmodule

// File: tb/sim_lcd4_ctrl.sv
module sim_lcd4_ctrl;
  localparam int CLK_HZ = 2_000_000;
  localparam int CPU = 2;
  localparam int C_PWR = 16000 * CPU;
  localparam int C_G1 = 5000 * CPU;
  localparam int C_GN = 64 * CPU;
  localparam int C_STB = 1 * CPU;
  localparam int BUSY_READS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_is_data = 1'b0, stat_req = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic cmd_ready, stat_valid, init_done, lcd_rs, lcd_rw, lcd_e, lcd_d_oe;
  logic [7:0] stat_byte;
  logic [3:0] lcd_d_out;
  logic [3:0] lcd_d_in = 4'h0;

  always #2 clk = ~clk;

  lcd4_ctrl #(.CLK_HZ(CLK_HZ), .TWO_LINES(1'b1), .CURSOR_ON(1'b1), .BLINK_ON(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_data(cmd_is_data),
    .cmd_byte(cmd_byte), .cmd_ready(cmd_ready), .stat_req(stat_req),
    .stat_valid(stat_valid), .stat_byte(stat_byte), .init_done(init_done),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_d_out(lcd_d_out),
    .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // display model
  int cyc = 0, first_rise = -1, last_fall = 0, e_start = 0;
  int init_cnt = 0, short_pulses = 0, float_viol = 0, busy_viol = 0;
  int gaps [0:3];
  logic [3:0] init_nib [0:3];
  logic [7:0] wr_byte [0:31];
  logic wr_rs [0:31];
  int wr_polls [0:31];
  int nwr = 0, reads_since = 0, busy_left = 0;
  logic [6:0] addr = 7'h00;
  logic e_prev = 1'b0, wr_half = 1'b0, rd_half = 1'b0;
  logic [3:0] hi_nib = 4'h0;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; e_prev = 1'b0;
    end else begin
      cyc++;
      if (lcd_e && lcd_rw && lcd_d_oe) float_viol++;
      if (lcd_e && !e_prev) begin
        if (first_rise < 0) first_rise = cyc;
        if (init_cnt >= 1 && init_cnt <= 4 && last_fall >= 0 && gaps[init_cnt-1] < 0)
          gaps[init_cnt-1] = cyc - last_fall;
        e_start = cyc;
        if (lcd_rw) begin
          lcd_d_in = rd_half ? {(busy_left > 0), addr[6:4]} : 4'h0;
          lcd_d_in = rd_half ? addr[3:0] : {(busy_left > 0), addr[6:4]};
        end
      end
      if (!lcd_e && e_prev) begin
        if (cyc - e_start < C_STB) short_pulses++;
        last_fall = cyc;
        if (init_cnt < 4) begin
          init_nib[init_cnt] = lcd_d_out;
          init_cnt++;
        end else if (lcd_rw) begin
          if (rd_half) begin
            if (busy_left > 0) busy_left--;
            reads_since++;
          end
          rd_half = ~rd_half;
        end else if (!wr_half) begin
          hi_nib = lcd_d_out;
          wr_half = 1'b1;
        end else begin
          wr_half = 1'b0;
          if (busy_left > 0) busy_viol++;
          if (nwr < 32) begin
            wr_byte[nwr] = {hi_nib, lcd_d_out};
            wr_rs[nwr] = lcd_rs;
            wr_polls[nwr] = reads_since;
          end
          if (lcd_rs) addr = addr + 7'd1;
          else if (hi_nib[3]) addr = {hi_nib[2:0], lcd_d_out};
          else if ({hi_nib, lcd_d_out} == 8'h01 || {hi_nib, lcd_d_out} == 8'h02) addr = 7'h00;
          nwr++;
          reads_since = 0;
          busy_left = BUSY_READS;
        end
      end
      e_prev = lcd_e;
    end
  end

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 e", int'(lcd_e), 0);
    check("R1 ready", int'(cmd_ready), 0);
    check("R1 done", int'(init_done), 0);
    check("R1 bus", int'({lcd_d_oe, lcd_d_out}), 5'h1F);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 e after release", int'(lcd_e), 0);
    check("R1 bus after release", int'({lcd_d_oe, lcd_d_out}), 5'h1F);
  endtask

  task automatic t_init;
    while (!init_done) @(negedge clk);
    check("R2 powerup", int'(first_rise >= C_PWR), 1);
    check("R3 nib0", int'(init_nib[0]), 3);
    check("R3 nib1", int'(init_nib[1]), 3);
    check("R3 nib2", int'(init_nib[2]), 3);
    check("R3 nib3", int'(init_nib[3]), 2);
    check("R3 gap0", int'(gaps[0] >= C_G1), 1);
    check("R3 gap1", int'(gaps[1] >= C_GN), 1);
    check("R3 gap2", int'(gaps[2] >= C_GN), 1);
    check("R3 gap3", int'(gaps[3] >= C_GN), 1);
    check("R4 count", nwr, 5);
    check("R4 fnset", int'(wr_byte[0]), 8'h28);
    check("R4 disp", int'(wr_byte[1]), 8'h0E);
    check("R4 clear", int'(wr_byte[2]), 8'h01);
    check("R4 home", int'(wr_byte[3]), 8'h02);
    check("R4 entry", int'(wr_byte[4]), 8'h06);
    for (int i = 0; i < 5; i++) check("R4 rs", int'(wr_rs[i]), 0);
  endtask

  task automatic send(input logic d, input logic [7:0] b);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_is_data = d; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R8 ready drops", int'(cmd_ready), 0);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic t_data;
    int k;
    k = nwr;
    send(1'b1, 8'h41);
    check("R5 byte", int'(wr_byte[k]), 8'h41);
    check("R6 rs data", int'(wr_rs[k]), 1);
    check("R7 polls", wr_polls[k], BUSY_READS + 1);
    check("R10 idle bus", int'({lcd_d_oe, lcd_d_out}), 5'h1F);
  endtask

  task automatic stat_read(input int exp, input string tag);
    while (!cmd_ready) @(negedge clk);
    stat_req = 1'b1;
    @(negedge clk);
    stat_req = 1'b0;
    while (!stat_valid) @(negedge clk);
    check(tag, int'(stat_byte), exp);
    @(negedge clk);
    check("R9 one-cycle valid", int'(stat_valid), 0);
  endtask

  task automatic t_addr_status;
    int k;
    k = nwr;
    send(1'b0, 8'hC5);
    check("R6 rs cmd", int'(wr_rs[k]), 0);
    check("R7 polls cmd", wr_polls[k], BUSY_READS + 1);
    stat_read(8'hC5, "R9 busy status 1");
    stat_read(8'hC5, "R9 busy status 2");
    stat_read(8'h45, "R9 clear status");
  endtask

  task automatic t_bus_rules;
    check("R5 short pulses", short_pulses, 0);
    check("R6 driven while reading", float_viol, 0);
    check("R7 write while busy", busy_viol, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) gaps[i] = -1;
    t_reset;
    t_init;
    t_data;
    t_addr_status;
    t_bus_rules;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule